// File: doc/BRIEF.md
# Alphanumeric Display Host-Bus Front End

This block is the host-side register interface of an eight-character alphanumeric display controller. A microprocessor reaches it over an asynchronous parallel bus made of an active-low select, separate active-low write and read strobes, an active-low flash-select line, five address bits and an 8-bit data path. The data path is split into an input, an output and an output enable, and the pad ring joins them into one bidirectional bus. Every bus input passes through a synchronizer into the controller's clock domain. The block then decodes each access to one of five storage sections: character codes, per-character flash bits, a pointer that picks a user-defined glyph, the rows of the user-defined glyph patterns, and a control word.

A write is committed once for each select-low period. It takes place on the cycle where the synchronized condition "select low and write low" first becomes true, and it uses the address and data sampled in that same cycle. A read drives the output while both select and read stay low. When the flash-select line is low, the access goes to the flash bits whatever the upper address bits say. The user-defined glyph rows are reached indirectly: the pointer register names the glyph, and the low address bits name the row.

Top module: `dispbus_front`

## Requirements
- R1: With `bus_flash_n` low, the access goes to the flash bit of the position given by `bus_addr[2:0]`, whatever `bus_addr[4:3]` holds. Only `bus_din[0]` is stored, and a read returns it in bit 0 with bits 7:1 zero.
- R2: With `bus_flash_n` high, `bus_addr[4:3]` selects the section: 2'b00 glyph pointer, 2'b01 glyph row RAM, 2'b10 control word, 2'b11 character RAM. Writes to the character RAM and the control word store all 8 bits.
- R3: `bus_addr[2:0]` selects the character position for character and flash accesses and the row for glyph-row accesses. These bits have no effect on pointer or control word accesses.
- R4: A write happens only while both `bus_ce_n` and `bus_wr_n` are low. A write strobe with the select high, or a select with no write strobe, changes no storage.
- R5: `bus_dout_en` is high only while both `bus_ce_n` and `bus_rd_n` are low (after synchronization). At all other times it is low, including during writes.
- R6: Only one write is performed for each select-low period. A second write strobe before `bus_ce_n` returns high is ignored.
- R7: The glyph row RAM is indexed by the 4-bit pointer together with `bus_addr[2:0]`, and each row stores 5 bits (`bus_din[4:0]`). Reads return the row in bits 4:0 and the pointer in bits 3:0, with the upper bits zero.
- R8: A low `rst_n` at a clock edge clears every storage section to zero and drops `bus_dout_en`.
- R9: A committed write uses the address and data present when the write condition began. Data that changes later in the same strobe is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ce_n | input | 1 | Active-low bus select |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_flash_n | input | 1 | Active-low flash-bit section select |
| bus_addr | input | 5 | Section bits [4:3], position/row bits [2:0] |
| bus_din | input | 8 | Write data from the bus |
| bus_dout | output | 8 | Read data toward the bus (zero when not driving) |
| bus_dout_en | output | 1 | Output enable for the bus drivers |

## Verification
A table of writes and read-backs covers every section. The same position index is used in different sections, so a decode that mixes up two sections reads back the wrong value. Flash accesses use every value of the section bits, which shows whether flash-select really overrides them. Pointer and control word accesses use varied low address bits, which shows that those bits are ignored. The glyph row RAM is written under two pointer values, and the bench checks that each row reads back only under its own pointer. Directed sequences then cover a strobe without select, a select without strobe, a double write strobe inside one select period, data changing during a held strobe, the output enable state in each strobe combination, and a reset in the middle of the run.

// File: rtl/dbf_pkg.sv
// Package: shared section type and address decode for the display bus front end.
// Assumes the section-select field is two bits wide and sits above the index bits.
package dbf_pkg;

    typedef enum logic [2:0] {
        SEC_FLASH  = 3'd0,
        SEC_UDCPTR = 3'd1,
        SEC_UDCROW = 3'd2,
        SEC_CTRL   = 3'd3,
        SEC_CHAR   = 3'd4
    } dbf_sec_e;

    // Maps the flash-select line and the section field to a storage section.
    function automatic dbf_sec_e dbf_section(input logic flash_n, input logic [1:0] sel);
        dbf_sec_e s;
        if (!flash_n) begin
            s = SEC_FLASH;
        end else begin
            case (sel)
                2'b00:   s = SEC_UDCPTR;
                2'b01:   s = SEC_UDCROW;
                2'b10:   s = SEC_CTRL;
                default: s = SEC_CHAR;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/dbf_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous bus inputs.
// Assumes each bit is sampled on its own; callers accept that a multi-bit
// field may be torn for a single cycle while it changes.
module dbf_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    // First stage samples the raw asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= din;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each later stage resamples the stage before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/dbf_decode.sv
// Module: turns synchronized bus strobes into one registered write request
// per select period and a combinational read selection.
// Assumes its inputs come from dbf_sync and are therefore clock-aligned.
module dbf_decode
    import dbf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3,
    localparam int ADDR_W = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_s,
    input  logic              wr_n_s,
    input  logic              rd_n_s,
    input  logic              flash_n_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    output logic              wr_en,
    output dbf_sec_e          wr_sec,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_active,
    output dbf_sec_e          rd_sec,
    output logic [IDX_W-1:0]  rd_idx
);

    logic wr_act;
    logic wr_act_q;
    logic used_q;
    logic commit;

    assign wr_act = !ce_n_s && !wr_n_s;
    assign commit = wr_act && !wr_act_q && !used_q;

    // Remembers the previous write condition for start-of-strobe detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_act_q <= 1'b0;
        else        wr_act_q <= wr_act;
    end

    // Locks out further writes until the select returns high.
    always_ff @(posedge clk) begin
        if (!rst_n)      used_q <= 1'b0;
        else if (ce_n_s) used_q <= 1'b0;
        else if (commit) used_q <= 1'b1;
    end

    // Captures the write request with the address and data seen at commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_sec  <= SEC_FLASH;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= commit;
            if (commit) begin
                wr_sec  <= dbf_section(flash_n_s, addr_s[ADDR_W-1:IDX_W]);
                wr_idx  <= addr_s[IDX_W-1:0];
                wr_data <= data_s;
            end
        end
    end

    // Read selection follows the synchronized address while the read is held.
    always_comb begin
        rd_active = !ce_n_s && !rd_n_s;
        rd_sec    = dbf_section(flash_n_s, addr_s[ADDR_W-1:IDX_W]);
        rd_idx    = addr_s[IDX_W-1:0];
    end

    // R4: a write request always follows a cycle with select and write strobe low.
    assert_write_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(!ce_n_s && !wr_n_s));

    // R6: a write request never lasts two cycles.
    assert_single_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R6: no new request while the select stays low after a commit.
    assert_no_rewrite_in_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ce_n_s) |=> !wr_en);

endmodule

// File: rtl/dbf_store.sv
// Module: the display storage sections (character codes, flash bits, glyph
// pointer, glyph rows, control word) with one write port and one read port.
// Assumes at most one write request per cycle from dbf_decode.
module dbf_store
    import dbf_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int IDX_W    = 3,
    parameter int PTR_W    = 4,
    parameter int ROW_BITS = 5,
    localparam int POSITIONS   = 2 ** IDX_W,
    localparam int UDC_ENTRIES = 2 ** (PTR_W + IDX_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  dbf_sec_e          wr_sec,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  dbf_sec_e          rd_sec,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0]   char_q  [POSITIONS];
    logic                flash_q [POSITIONS];
    logic [ROW_BITS-1:0] udc_q   [UDC_ENTRIES];
    logic [PTR_W-1:0]    ptr_q;
    logic [DATA_W-1:0]   ctrl_q;

    // Character RAM: full-width codes, one per position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < POSITIONS; i++) char_q[i] <= '0;
        end else if (wr_en && wr_sec == SEC_CHAR) begin
            char_q[wr_idx] <= wr_data;
        end
    end

    // Flash RAM: one bit per position, taken from data bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < POSITIONS; i++) flash_q[i] <= 1'b0;
        end else if (wr_en && wr_sec == SEC_FLASH) begin
            flash_q[wr_idx] <= wr_data[0];
        end
    end

    // Glyph row RAM: indexed by pointer and row, narrow rows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < UDC_ENTRIES; i++) udc_q[i] <= '0;
        end else if (wr_en && wr_sec == SEC_UDCROW) begin
            udc_q[{ptr_q, wr_idx}] <= wr_data[ROW_BITS-1:0];
        end
    end

    // Glyph pointer and control word registers; the index bits are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (wr_sec == SEC_UDCPTR) ptr_q  <= wr_data[PTR_W-1:0];
            if (wr_sec == SEC_CTRL)   ctrl_q <= wr_data;
        end
    end

    // Read mux; unused upper bits of narrow sections read as zero.
    always_comb begin
        rd_data = '0;
        case (rd_sec)
            SEC_FLASH:  rd_data[0]            = flash_q[rd_idx];
            SEC_UDCPTR: rd_data[PTR_W-1:0]    = ptr_q;
            SEC_UDCROW: rd_data[ROW_BITS-1:0] = udc_q[{ptr_q, rd_idx}];
            SEC_CTRL:   rd_data               = ctrl_q;
            default:    rd_data               = char_q[rd_idx];
        endcase
    end

    // R2: a character write lands at its position with the full data word.
    assert_char_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sec == SEC_CHAR) |=> char_q[$past(wr_idx)] == $past(wr_data));

    // R3: control writes ignore the index and keep the whole word.
    assert_ctrl_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sec == SEC_CTRL) |=> ctrl_q == $past(wr_data));

    // R8: leaving reset, the registers and sampled storage are zero.
    assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_q == '0 && ptr_q == '0 && char_q[0] == '0
                          && !flash_q[0] && udc_q[0] == '0));

endmodule

// File: rtl/dispbus_front.sv
// Module: top of the display host-bus front end. It synchronizes the bus,
// decodes accesses and holds the storage sections. The bidirectional data
// bus is split into input, output and output enable for the pad ring.
// Assumes bus strobes stay low for several clock cycles.
module dispbus_front
    import dbf_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int IDX_W       = 3,
    parameter int PTR_W       = 4,
    parameter int ROW_BITS    = 5,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W = IDX_W + 2,
    localparam int BUS_W  = 4 + ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_wr_n,
    input  logic              bus_rd_n,
    input  logic              bus_flash_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en
);

    localparam logic [BUS_W-1:0] SYNC_RST = {4'b1111, {(ADDR_W + DATA_W){1'b0}}};

    logic [BUS_W-1:0]  raw_bus;
    logic [BUS_W-1:0]  sync_bus;
    logic              ce_n_s, wr_n_s, rd_n_s, flash_n_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;

    logic              wr_en;
    dbf_sec_e          wr_sec;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic              rd_active;
    dbf_sec_e          rd_sec;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_data;

    assign raw_bus = {bus_ce_n, bus_wr_n, bus_rd_n, bus_flash_n, bus_addr, bus_din};
    assign {ce_n_s, wr_n_s, rd_n_s, flash_n_s, addr_s, data_s} = sync_bus;

    dbf_sync #(
        .W       (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_bus),
        .dout  (sync_bus)
    );

    dbf_decode #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n_s    (ce_n_s),
        .wr_n_s    (wr_n_s),
        .rd_n_s    (rd_n_s),
        .flash_n_s (flash_n_s),
        .addr_s    (addr_s),
        .data_s    (data_s),
        .wr_en     (wr_en),
        .wr_sec    (wr_sec),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_active (rd_active),
        .rd_sec    (rd_sec),
        .rd_idx    (rd_idx)
    );

    dbf_store #(
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .PTR_W    (PTR_W),
        .ROW_BITS (ROW_BITS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sec  (wr_sec),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_sec  (rd_sec),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    // Drive the bus only during a read; park the output at zero otherwise.
    always_comb begin
        bus_dout_en = rd_active;
        bus_dout    = rd_active ? rd_data : '0;
    end

    generate
        if (SYNC_STAGES == 2) begin : g_chk2
            // R5: the driver is enabled only after select and read were both low.
            assert_drive_needs_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
                bus_dout_en |-> $past(!bus_ce_n && !bus_rd_n, 2));
        end
    endgenerate

    // R7: glyph row and pointer reads never set the bits above their width.
    assert_narrow_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dout_en && (rd_sec == SEC_UDCROW || rd_sec == SEC_UDCPTR))
            |-> bus_dout[DATA_W-1:ROW_BITS] == '0);

    // R5: no drive while a write strobe is active and the read strobe is high.
    assert_quiet_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n_s && !wr_n_s && rd_n_s) |-> !bus_dout_en);

endmodule

// File: tb/tb_dispbus_front.sv
`timescale 1ns/1ps
module tb_dispbus_front;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, fl_n = 1'b1;
    logic [4:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       doe;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dispbus_front dut (
        .clk (clk), .rst_n (rst_n),
        .bus_ce_n (ce_n), .bus_wr_n (wr_n), .bus_rd_n (rd_n),
        .bus_flash_n (fl_n), .bus_addr (addr), .bus_din (din),
        .bus_dout (dout), .bus_dout_en (doe)
    );

    // Entry: {is_write, flash_n, addr[4:0], data or expected}
    localparam int NV = 26;
    localparam logic [14:0] VEC [NV] = '{
        {1'b1, 1'b1, 5'b11000, 8'h41},  // R2 char pos0
        {1'b1, 1'b1, 5'b11111, 8'h5A},  // R2 char pos7
        {1'b1, 1'b0, 5'b00010, 8'hFF},  // R1 flash pos2, only bit0 kept
        {1'b1, 1'b0, 5'b11101, 8'h01},  // R1 flash pos5 with section bits 11
        {1'b1, 1'b1, 5'b10110, 8'hC3},  // R3 ctrl, index ignored
        {1'b1, 1'b1, 5'b00011, 8'hA7},  // R7 pointer = 7
        {1'b1, 1'b1, 5'b01010, 8'hFF},  // R7 glyph 7 row 2, 5 bits kept
        {1'b0, 1'b1, 5'b11000, 8'h41},  // R2
        {1'b0, 1'b1, 5'b11111, 8'h5A},  // R2
        {1'b0, 1'b1, 5'b11010, 8'h00},  // R1 flash write left char pos2 alone
        {1'b0, 1'b1, 5'b11101, 8'h00},  // R1 char pos5 untouched
        {1'b0, 1'b0, 5'b01010, 8'h01},  // R1 flash pos2 read via section 01
        {1'b0, 1'b0, 5'b00101, 8'h01},  // R1 flash pos5
        {1'b0, 1'b0, 5'b10000, 8'h00},  // R3 flash pos0 unwritten
        {1'b0, 1'b1, 5'b10001, 8'hC3},  // R3 ctrl via other index
        {1'b0, 1'b1, 5'b00110, 8'h07},  // R7 pointer, upper zero
        {1'b0, 1'b1, 5'b01010, 8'h1F},  // R7 row 2
        {1'b0, 1'b1, 5'b01011, 8'h00},  // R3 row 3 distinct
        {1'b1, 1'b1, 5'b10000, 8'h3C},  // R3 ctrl rewrite
        {1'b0, 1'b1, 5'b10111, 8'h3C},  // R3
        {1'b1, 1'b1, 5'b00000, 8'h02},  // R7 pointer = 2
        {1'b1, 1'b1, 5'b01010, 8'h0A},  // R7 glyph 2 row 2
        {1'b0, 1'b1, 5'b01010, 8'h0A},  // R7
        {1'b1, 1'b1, 5'b00111, 8'h07},  // R7 pointer back to 7
        {1'b0, 1'b1, 5'b01010, 8'h1F},  // R7 glyph 7 kept its row
        {1'b0, 1'b1, 5'b00000, 8'h07}   // R7
    };

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic f, input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        fl_n = f; addr = a; din = d; ce_n = 1'b0; wr_n = 1'b0;
        idle(6);
        wr_n = 1'b1; ce_n = 1'b1;
        idle(4);
    endtask

    task automatic bus_read(input logic f, input logic [4:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        fl_n = f; addr = a; ce_n = 1'b0; rd_n = 1'b0;
        idle(6);
        check(tag, {doe, dout}, {1'b1, e});
        rd_n = 1'b1; ce_n = 1'b1;
        idle(4);
        check({tag, " release R5"}, {8'h00, doe}, 9'h000);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(5);
        rst_n = 1'b1;
        idle(2);
    endtask

    initial begin
        idle(5);
        check("R8 reset drive off", {8'h00, doe}, 9'h000);
        rst_n = 1'b1;
        idle(3);
        bus_read(1'b1, 5'b11000, 8'h00, "R8 char after reset");
        bus_read(1'b1, 5'b10000, 8'h00, "R8 ctrl after reset");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][14]) bus_write(VEC[i][13], VEC[i][12:8], VEC[i][7:0]);
            else bus_read(VEC[i][13], VEC[i][12:8], VEC[i][7:0], $sformatf("table %0d", i));
        end

        // R4: write strobe with select high changes nothing.
        @(negedge clk); fl_n = 1'b1; addr = 5'b11000; din = 8'hEE; wr_n = 1'b0;
        idle(6); wr_n = 1'b1; idle(4);
        bus_read(1'b1, 5'b11000, 8'h41, "R4 strobe without select");
        // R4/R5: select low with no strobe: no write and no drive.
        @(negedge clk); addr = 5'b11111; din = 8'hEE; ce_n = 1'b0;
        idle(6);
        check("R5 select only", {8'h00, doe}, 9'h000);
        ce_n = 1'b1; idle(4);
        bus_read(1'b1, 5'b11111, 8'h5A, "R4 select without strobe");
        // R5: read strobe with select high does not drive.
        @(negedge clk); rd_n = 1'b0; idle(6);
        check("R5 read without select", {8'h00, doe}, 9'h000);
        rd_n = 1'b1; idle(4);

        // R6: second write strobe in one select period is ignored.
        @(negedge clk); addr = 5'b11011; din = 8'h11; ce_n = 1'b0; wr_n = 1'b0;
        idle(6); wr_n = 1'b1; idle(4);
        din = 8'h22; wr_n = 1'b0; idle(6);
        check("R5 no drive during write", {8'h00, doe}, 9'h000);
        wr_n = 1'b1; ce_n = 1'b1; idle(4);
        bus_read(1'b1, 5'b11011, 8'h11, "R6 one write per select");

        // R9: data changed while the strobe is held is not stored.
        @(negedge clk); addr = 5'b11100; din = 8'h33; ce_n = 1'b0; wr_n = 1'b0;
        idle(6); din = 8'h44; addr = 5'b11110; idle(6);
        wr_n = 1'b1; ce_n = 1'b1; idle(4);
        bus_read(1'b1, 5'b11100, 8'h33, "R9 sampled data kept");
        bus_read(1'b1, 5'b11110, 8'h00, "R9 late address unused");

        // R8: reset in mid run clears every section.
        do_reset();
        bus_read(1'b1, 5'b11000, 8'h00, "R8 char cleared");
        bus_read(1'b0, 5'b00010, 8'h00, "R8 flash cleared");
        bus_read(1'b1, 5'b10000, 8'h00, "R8 ctrl cleared");
        bus_read(1'b1, 5'b00000, 8'h00, "R8 pointer cleared");
        bus_read(1'b1, 5'b01010, 8'h00, "R8 glyph row cleared");

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule